// File: doc/BRIEF.md
# Two-Region SMBus Byte Memory Slave

This block is a bus slave that sits on a two-wire SMBus/I2C-style link and exposes a 256-location byte space. The lower 128 locations form an information ROM: the bus can only read them, and the local side loads them through a preload port. The upper 128 locations form a scratch memory that the bus can both read and write. The command byte of each transaction is also the location address. Its top bit picks the region: 0 for the ROM half, 1 for the scratch half.

The block oversamples SCL and SDA with the system clock. It pulls SDA low through an open-drain enable and recognises two transactions only. A Write Byte frame carries the device address with the write bit, a command and one data byte. A Read Byte frame carries the device address with the write bit and a command, then a repeated START, the device address with the read bit, and one data byte that the slave returns. The 7-bit device address is 1010, then 0, then two strap bits. Writes aimed at the ROM half are acknowledged but leave the ROM untouched.

Top module: `smbus_dual_eeprom`

## Requirements
- R1: The slave acknowledges (pulls SDA low during the 9th clock) an address byte whose upper 7 bits equal {4'b1010, 1'b0, strap[1:0]}.
- R2: An address that differs in any bit, including bit 2 of the 7-bit address set to 1, is not acknowledged. The slave then ignores the bus until the next START, and memory is unchanged.
- R3: In a Write Byte frame (address with bit 0 = 0, command byte, data byte), all three bytes are acknowledged.
- R4: A Write Byte whose command has bit 7 = 1 stores the data byte in scratch location command[6:0]. The store happens at the end of the data byte's ACK clock.
- R5: A Write Byte whose command has bit 7 = 0 is acknowledged at every byte, but the ROM location keeps its old value.
- R6: In a Read Byte frame, the slave acknowledges the address with the read bit (bit 0 = 1) after a repeated START. It then sends the addressed location's byte MSB first and releases SDA after the 8th data bit.
- R7: An address with the read bit that is not preceded by a command byte in the same frame (since the last STOP) is not acknowledged.
- R8: A frame that ends with STOP before the data byte's ACK completes leaves memory unchanged.
- R9: A local preload write (pre_we = 1 at a clock edge) stores pre_data in ROM location pre_addr, and a later bus read of command {1'b0, pre_addr} returns it.
- R10: The slave changes SDA only while SCL is low. START or STOP resets the bit state at any point, and after a STOP the slave does not drive SDA.
- R11: While and after reset, sda_oe is 0.
- R12: A byte that follows the data byte of a Write Byte frame is not acknowledged, and the completed write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap | input | 2 | Low two bits of the 7-bit device address |
| pre_we | input | 1 | Preload write strobe for the ROM half |
| pre_addr | input | 7 | Preload location within the ROM half |
| pre_data | input | 8 | Preload byte |

## Verification
The bench uses the default parameters: an 8-bit location space, a 4'b1010 device prefix and a two-stage synchronizer. With these values, every region boundary (0x00, 0x7F, 0x80, 0xFF) is a plain bus transaction away. The straps are changed mid-run, so both the accepted and the refused addresses move. An open-drain bus model with a bit-banging master drives frames that end normally, end early, or run one byte long. Every acknowledge and every returned byte is checked against a model memory.

// File: rtl/smbus_dual_eeprom.sv
module smbus_dual_eeprom #(
  parameter int          AW      = 8,
  parameter logic [3:0]  DEV_HI  = 4'b1010,
  parameter int          SYNC    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic [1:0]    strap,
  input  logic          pre_we,
  input  logic [AW-2:0] pre_addr,
  input  logic [7:0]    pre_data
);
  localparam int HALF = 1 << (AW - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_IGN} st_t;

  logic [SYNC-1:0] scl_sh, sda_sh;
  logic            scl_s, sda_s, scl_d, sda_d;
  logic            scl_rise, scl_fall, start_det, stop_det;

  st_t        st;
  logic [7:0] shreg, cmd_q, dat_q;
  logic [3:0] bitcnt;
  logic [1:0] bytec;
  logic       cmd_ok, rd_go, wr_pend, wr_fire, addr_ok, ignoring;
  logic [7:0] rd_byte;

  logic [7:0] rom [HALF];
  logic [7:0] scr [HALF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC-2:0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_s     = scl_sh[SYNC-1];
  assign sda_s     = sda_sh[SYNC-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

  assign addr_ok  = shreg[7:1] == {DEV_HI, 1'b0, strap};
  assign rd_byte  = cmd_q[AW-1] ? scr[cmd_q[AW-2:0]] : rom[cmd_q[AW-2:0]];
  assign wr_fire  = (st == ST_ACK) & scl_fall & wr_pend & ~start_det & ~stop_det;
  assign sda_oe   = (st == ST_ACK) | ((st == ST_TX) & ~shreg[7]);
  assign ignoring = (st == ST_IGN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      shreg   <= 8'hFF;
      cmd_q   <= '0;
      dat_q   <= '0;
      bitcnt  <= '0;
      bytec   <= '0;
      cmd_ok  <= 1'b0;
      rd_go   <= 1'b0;
      wr_pend <= 1'b0;
    end else if (stop_det) begin
      st      <= ST_IDLE;
      cmd_ok  <= 1'b0;
      wr_pend <= 1'b0;
    end else if (start_det) begin
      st      <= ST_RX;
      bitcnt  <= '0;
      bytec   <= '0;
      wr_pend <= 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (bytec != 2'd3) bytec <= bytec + 2'd1;
            case (bytec)
              2'd0: begin
                if (!addr_ok) begin
                  st     <= ST_IGN;
                  cmd_ok <= 1'b0;
                end else if (!shreg[0]) begin
                  st     <= ST_ACK;
                  rd_go  <= 1'b0;
                  cmd_ok <= 1'b0;
                end else if (cmd_ok) begin
                  st    <= ST_ACK;
                  rd_go <= 1'b1;
                end else begin
                  st <= ST_IGN;
                end
              end
              2'd1: begin
                cmd_q  <= shreg;
                cmd_ok <= 1'b1;
                st     <= ST_ACK;
              end
              2'd2: begin
                dat_q   <= shreg;
                wr_pend <= 1'b1;
                st      <= ST_ACK;
              end
              default: st <= ST_IGN;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitcnt  <= '0;
            wr_pend <= 1'b0;
            if (rd_go) begin
              st    <= ST_TX;
              shreg <= rd_byte;
            end else begin
              st <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) st <= ST_IGN;
            else shreg <= {shreg[6:0], 1'b0};
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire && cmd_q[AW-1]) scr[cmd_q[AW-2:0]] <= dat_q;
    if (pre_we) rom[pre_addr] <= pre_data;
  end
endmodule

module smbus_dual_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic stop_det,
  input logic wr_fire,
  input logic ignoring
);
  // R10
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  // R4
  write_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> $past(sda_oe));
  // R4
  release_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !sda_oe);
  // R2
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);
endmodule

bind smbus_dual_eeprom smbus_dual_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .stop_det(stop_det), .wr_fire(wr_fire), .ignoring(ignoring)
);

// File: tb/sim_smbus_dual_eeprom.sv
module sim_smbus_dual_eeprom;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic pre_we = 1'b0;
  logic [6:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic sda_oe;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  smbus_dual_eeprom u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .strap(strap), .pre_we(pre_we),
    .pre_addr(pre_addr), .pre_data(pre_data)
  );

  int n_cmp = 0, n_bad = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [8:0] obs_q[$];
  logic [7:0] m_rom [128];
  logic [7:0] m_scr [128];

  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && obs_q.size() > 0) begin
        logic [8:0] e, o;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        o = obs_q.pop_front();
        n_cmp++;
        if (o !== e) begin
          n_bad++;
          $display("FAIL %s: got %0h expected %0h", t, o, e);
        end
      end
    end
  end

  function automatic logic [6:0] dev();
    return {4'b1010, 1'b0, strap};
  endfunction

  task automatic expect_v(input logic [8:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic bstop();
    hw(); sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic put_bit(input logic b);
    hw(); sda_m = b; hw(); scl_m = 1'b1; hw(); hw(); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    hw(); sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); b = sda_line; hw(); scl_m = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] v);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    obs_q.push_back({8'h00, a});
  endtask

  task automatic rbyte();
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(1'b1);
    obs_q.push_back({1'b0, v});
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] c, input logic [7:0] d, input string t);
    logic hit;
    hit = (a == dev());
    for (int i = 0; i < 3; i++) expect_v(hit ? 9'h0 : 9'h1, t);
    if (hit && c[7]) m_scr[c[6:0]] = d;
    bstart(); wbyte({a, 1'b0}); wbyte(c); wbyte(d); bstop();
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] c, input string t);
    logic hit;
    hit = (a == dev());
    for (int i = 0; i < 3; i++) expect_v(hit ? 9'h0 : 9'h1, t);
    if (hit) expect_v({1'b0, c[7] ? m_scr[c[6:0]] : m_rom[c[6:0]]}, t);
    else expect_v(9'h0FF, t);
    bstart(); wbyte({a, 1'b0}); wbyte(c);
    bstart(); wbyte({a, 1'b1}); rbyte(); bstop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11: output low in reset
    expect_v(9'h0, "R11 in reset"); obs_q.push_back({8'h0, sda_oe});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_v(9'h0, "R11 after reset"); obs_q.push_back({8'h0, sda_oe});

    // R9: preload ROM half
    for (int i = 0; i < 128; i++) begin
      pre_we = 1'b1; pre_addr = 7'(i); pre_data = 8'(i * 37 + 5);
      m_rom[i] = 8'(i * 37 + 5);
      @(negedge clk);
    end
    pre_we = 1'b0;

    // R6 R9 R1: reads from ROM half boundaries
    do_read(dev(), 8'h00, "R9 rom 00");
    do_read(dev(), 8'h7F, "R6 rom 7F");
    do_read(dev(), 8'h2A, "R1 rom 2A");

    // R3 R4: scratch writes and read-back
    do_write(dev(), 8'h80, 8'h5A, "R3 wr 80");
    do_write(dev(), 8'hFF, 8'hC3, "R3 wr FF");
    do_read(dev(), 8'h80, "R4 rd 80");
    do_read(dev(), 8'hFF, "R4 rd FF");

    // R5: write to ROM acked, no change
    do_write(dev(), 8'h10, ~m_rom[16], "R5 wr rom");
    do_read(dev(), 8'h10, "R5 rom 10 kept");

    // R2: wrong straps and bit 2 set
    do_write(7'b1010001, 8'h80, 8'h11, "R2 strap miss");
    do_write(7'b1010100, 8'h80, 8'h22, "R2 bit2 miss");
    do_read(dev(), 8'h80, "R2 80 kept");
    do_read(7'b1110000, 8'h80, "R2 read miss");

    // R1: other strap value
    strap = 2'b10;
    repeat (4) @(negedge clk);
    do_read(7'b1010010, 8'h05, "R1 strap 10");
    do_write(7'b1010010, 8'h90, 8'hA7, "R1 wr 90");
    do_read(7'b1010010, 8'h90, "R1 rd 90");
    do_read(7'b1010000, 8'h90, "R1 old addr refused");

    // R7: read address with no command
    expect_v(9'h1, "R7 no command");
    bstart(); wbyte({dev(), 1'b1}); bstop();

    // R8: frames ending early
    do_write(dev(), 8'h85, 8'h66, "R8 setup");
    expect_v(9'h0, "R8 early a"); expect_v(9'h0, "R8 early c");
    bstart(); wbyte({dev(), 1'b0}); wbyte(8'h85); bstop();
    expect_v(9'h0, "R8 mid a"); expect_v(9'h0, "R8 mid c");
    bstart(); wbyte({dev(), 1'b0}); wbyte(8'h85);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bstop();
    do_read(dev(), 8'h85, "R8 85 kept");

    // R12: extra byte refused, write kept
    for (int i = 0; i < 3; i++) expect_v(9'h0, "R12 acks");
    expect_v(9'h1, "R12 extra nack");
    m_scr[7'h0A] = 8'h3C;
    bstart(); wbyte({dev(), 1'b0}); wbyte(8'h8A); wbyte(8'h3C); wbyte(8'hEE); bstop();
    do_read(dev(), 8'h8A, "R12 8A written");

    // R10: released after STOP
    repeat (4) @(negedge clk);
    expect_v(9'h0, "R10 released"); obs_q.push_back({8'h0, sda_oe});

    repeat (20) @(negedge clk);
    if (exp_q.size() != obs_q.size()) begin
      n_cmp++;
      n_bad++;
      $display("FAIL queue: got %0d expected %0d", obs_q.size(), exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule